// File: doc/BRIEF.md
# DMA Interrupt Flag and Enable Register

This block holds the shared interrupt register of a multi-channel DMA engine. One 32-bit word combines auxiliary control bits, a per-channel enable for completion interrupts, a global enable, a forced bus-error bit, one completion flag per channel and a derived master flag. Software writes the control fields directly. It clears completion flags by writing ones to them. The transfer engine raises a flag by pulsing that channel's done input.

The master flag is tracked by a two-state machine. In state MST_QUIET the master flag reads 0. The transition QUIET to RAISED is taken when the bus-error bit is set, or when the global enable is set and at least one completion flag is set. The transition RAISED to QUIET is taken when that condition stops holding. Only the QUIET to RAISED transition sends a one-cycle pulse to the system interrupt controller. Staying in RAISED, or any other transition, sends nothing.

The register updates on every rising clock edge. A write and any done events from the same cycle appear together in the read value one cycle later. The master flag and the interrupt pulse appear in that same cycle, and both are computed from the updated register contents.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Reset clears every bit of the register and holds the interrupt pulse low.
- R2: A write stores bits 5:0, bit 15 and bits 23:16 from the write data. Bits 14:6 always read 0.
- R3: Writing 1 to flag bit 24+n clears that flag. Writing 0 to it leaves the flag unchanged.
- R4: A done pulse on channel n sets flag bit 24+n only if enable bit 16+n already held 1 before that clock edge. Otherwise the pulse is ignored.
- R5: When a done pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Bit 31 reads 1 exactly when bit 15 is 1, or when bit 23 is 1 and any of bits 30:24 is 1. It returns to 0 as soon as that condition is gone.
- R7: The interrupt pulse is high for exactly one cycle. That cycle is the one in which bit 31 first reads 1 after having read 0.
- R8: While bit 31 stays 1, further flags, writes or bus-error settings produce no further pulse.
- R9: Writes cannot set bits 30:24 and cannot change bit 31 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| done | input | NUM_CH | Per-channel transfer-complete pulses |
| rd_data | output | 32 | Current register contents |
| irq_pulse | output | 1 | One-cycle interrupt request to the system controller |

## Verification
The bench goes after the cases where a done pulse and a clearing write land on the same flag in the same cycle. A design that gave the clear priority would lose that completion. It also delivers done pulses to channels whose enable is off. A design without gating would set flags there and could raise the master flag.

It sets a second flag, and it sets the bus-error bit, while the master flag is already 1. An edge detector that fired on the level would send a repeat interrupt in those cases. It clears the last flag and checks that the master flag drops. A sticky master flag would stay at 1 there and would block every later interrupt.

// File: rtl/dicr_pkg.sv
package dicr_pkg;
    localparam int REG_W      = 32;
    localparam int MAX_CH     = 7;
    localparam int AUX_W      = 6;
    localparam int BUSERR_BIT = 15;
    localparam int EN_LSB     = 16;
    localparam int GEN_BIT    = 23;
    localparam int FLAG_LSB   = 24;
    localparam int MASTER_BIT = 31;

    typedef enum logic [0:0] {
        MST_QUIET  = 1'b0,
        MST_RAISED = 1'b1
    } mst_state_e;
endpackage

// File: rtl/dicr_ctrl_reg.sv
module dicr_ctrl_reg
    import dicr_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [AUX_W-1:0]     aux_q,
    output logic                 buserr_q,
    output logic [NUM_CH-1:0]    en_q,
    output logic                 gen_q,
    output logic                 buserr_d,
    output logic                 gen_d
);
    logic [AUX_W-1:0]  aux_d;
    logic [NUM_CH-1:0] en_d;

    // Next values of the plain writable fields
    always_comb begin
        aux_d    = aux_q;
        buserr_d = buserr_q;
        en_d     = en_q;
        gen_d    = gen_q;
        if (wr_en) begin
            aux_d    = wr_data[AUX_W-1:0];
            buserr_d = wr_data[BUSERR_BIT];
            en_d     = wr_data[EN_LSB +: NUM_CH];
            gen_d    = wr_data[GEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aux_q    <= '0;
            buserr_q <= 1'b0;
            en_q     <= '0;
            gen_q    <= 1'b0;
        end else begin
            aux_q    <= aux_d;
            buserr_q <= buserr_d;
            en_q     <= en_d;
            gen_q    <= gen_d;
        end
    end
endmodule

// File: rtl/dicr_flag_bank.sv
module dicr_flag_bank #(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] done,
    input  logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] flag_q,
    output logic [NUM_CH-1:0] flag_d,
    output logic              any_flag_d
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
        logic clr_hit;
        logic set_hit;

        // A gated completion outranks a same-cycle clear
        assign clr_hit    = wr_en & clr_bits[ch];
        assign set_hit    = done[ch] & en_q[ch];
        assign flag_d[ch] = (flag_q[ch] & ~clr_hit) | set_hit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[ch] <= 1'b0;
            else        flag_q[ch] <= flag_d[ch];
        end
    end

    assign any_flag_d = |flag_d;
endmodule

// File: rtl/dicr_master_fsm.sv
module dicr_master_fsm
    import dicr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic buserr_d,
    input  logic gen_d,
    input  logic any_flag_d,
    output logic master_q,
    output logic irq_pulse
);
    mst_state_e state_q;
    mst_state_e state_d;
    logic       raise_cond;

    assign raise_cond = buserr_d | (gen_d & any_flag_d);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MST_QUIET:  if (raise_cond)  state_d = MST_RAISED;
            MST_RAISED: if (!raise_cond) state_d = MST_QUIET;
            default:                     state_d = MST_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MST_QUIET;
        else        state_q <= state_d;
    end

    // Output register: pulse only on the QUIET to RAISED transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= (state_q == MST_QUIET) && (state_d == MST_RAISED);
    end

    assign master_q = (state_q == MST_RAISED);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dicr_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [NUM_CH-1:0]    done,
    output logic [REG_W-1:0]     rd_data,
    output logic                 irq_pulse
);
    logic [AUX_W-1:0]  aux_q;
    logic              buserr_q, buserr_d;
    logic [NUM_CH-1:0] en_q;
    logic              gen_q, gen_d;
    logic [NUM_CH-1:0] flag_q, flag_d;
    logic              any_flag_d;
    logic              master_q;

    dicr_ctrl_reg #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .aux_q    (aux_q),
        .buserr_q (buserr_q),
        .en_q     (en_q),
        .gen_q    (gen_q),
        .buserr_d (buserr_d),
        .gen_d    (gen_d)
    );

    dicr_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .clr_bits   (wr_data[FLAG_LSB +: NUM_CH]),
        .done       (done),
        .en_q       (en_q),
        .flag_q     (flag_q),
        .flag_d     (flag_d),
        .any_flag_d (any_flag_d)
    );

    dicr_master_fsm u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .buserr_d   (buserr_d),
        .gen_d      (gen_d),
        .any_flag_d (any_flag_d),
        .master_q   (master_q),
        .irq_pulse  (irq_pulse)
    );

    always_comb begin
        rd_data                        = '0;
        rd_data[AUX_W-1:0]             = aux_q;
        rd_data[BUSERR_BIT]            = buserr_q;
        rd_data[EN_LSB +: NUM_CH]      = en_q;
        rd_data[GEN_BIT]               = gen_q;
        rd_data[FLAG_LSB +: NUM_CH]    = flag_q;
        rd_data[MASTER_BIT]            = master_q;
    end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
    import dicr_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [NUM_CH-1:0] done,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq_pulse
);
    AST_MASTER_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[MASTER_BIT] == (rd_data[BUSERR_BIT] |
                                (rd_data[GEN_BIT] & |rd_data[FLAG_LSB +: NUM_CH]))); // R6

    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> rd_data[MASTER_BIT]); // R7

    AST_RISE_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[MASTER_BIT] |=> (rd_data[MASTER_BIT] == irq_pulse)); // R7

    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[MASTER_BIT] |=> !irq_pulse); // R8

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[FLAG_LSB+n] && !(wr_en && wr_data[FLAG_LSB+n])) |=> rd_data[FLAG_LSB+n]); // R3

        AST_DONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_data[EN_LSB+n] && !rd_data[FLAG_LSB+n]) |=> !rd_data[FLAG_LSB+n]); // R4

        AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (done[n] && rd_data[EN_LSB+n]) |=> rd_data[FLAG_LSB+n]); // R5
    end
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .done      (done),
    .rd_data   (rd_data),
    .irq_pulse (irq_pulse)
);

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
    localparam int NUM_CH = 7;
    localparam int VEC_W  = 1 + 32 + NUM_CH + 32 + 1;
    localparam int NVEC   = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [NUM_CH-1:0] done = '0;
    logic [31:0]       rd_data;
    logic              irq_pulse;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dma_irq_ctrl #(.NUM_CH(NUM_CH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .done      (done),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    // {wr_en, wr_data, done, expected rd_data, expected irq_pulse}; one per cycle, state carries
    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {1'b1, 32'hFFFF_FFFF, 7'h00, 32'h80FF_803F, 1'b1}, // R2 R9 R6 R7: bus error raises master
        {1'b1, 32'h00FF_0000, 7'h00, 32'h00FF_0000, 1'b0}, // R6: master drops
        {1'b0, 32'h0000_0000, 7'h01, 32'h81FF_0000, 1'b1}, // R4 R7: ch0 done
        {1'b0, 32'h0000_0000, 7'h02, 32'h83FF_0000, 1'b0}, // R8: second flag, no pulse
        {1'b1, 32'h01FF_0000, 7'h00, 32'h82FF_0000, 1'b0}, // R3: clear ch0
        {1'b1, 32'h02FF_0000, 7'h00, 32'h00FF_0000, 1'b0}, // R3 R6: clear ch1, master drops
        {1'b1, 32'h0001_0000, 7'h00, 32'h0001_0000, 1'b0}, // R2: only ch0 enabled
        {1'b0, 32'h0000_0000, 7'h7F, 32'h0101_0000, 1'b0}, // R4 R6: gated, global off
        {1'b1, 32'h0081_0000, 7'h00, 32'h8181_0000, 1'b1}, // R7 R3: enable raises master
        {1'b1, 32'h0181_0000, 7'h01, 32'h8181_0000, 1'b0}, // R5: done beats clear
        {1'b1, 32'h0081_803F, 7'h00, 32'h8181_803F, 1'b0}, // R8: bus error while raised
        {1'b1, 32'h7F00_0000, 7'h00, 32'h0000_0000, 1'b0}, // R3 R6: all clear
        {1'b1, 32'h0000_7FC0, 7'h00, 32'h0000_0000, 1'b0}, // R2: gap bits read 0
        {1'b1, 32'h0000_8000, 7'h00, 32'h8000_8000, 1'b1}, // R6 R7: bus error alone
        {1'b1, 32'h0000_0000, 7'h00, 32'h0000_0000, 1'b0}  // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [31:0] d, input logic [NUM_CH-1:0] dn);
        wr_en   = w;
        wr_data = d;
        done    = dn;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", rd_data, 32'h0);
        check("R1 reset irq", {31'h0, irq_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        drive(VEC[0][VEC_W-1], VEC[0][VEC_W-2 -: 32], VEC[0][VEC_W-34 -: NUM_CH]);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            check($sformatf("R2-R9 vector %0d rd_data", i), rd_data, VEC[i][32:1]);
            check($sformatf("R7 R8 vector %0d irq", i), {31'h0, irq_pulse}, {31'h0, VEC[i][0]});
            if (i + 1 < NVEC)
                drive(VEC[i+1][VEC_W-1], VEC[i+1][VEC_W-2 -: 32], VEC[i+1][VEC_W-34 -: NUM_CH]);
            else
                drive(1'b0, 32'h0, '0);
        end

        // R7: pulse lasts one cycle only
        drive(1'b1, 32'h0000_8000, '0);
        @(negedge clk);
        check("R7 pulse on rise", {31'h0, irq_pulse}, 32'h1);
        drive(1'b0, 32'h0, '0);
        @(negedge clk);
        check("R7 pulse single cycle", {31'h0, irq_pulse}, 32'h0);
        check("R8 state held", rd_data, 32'h8000_8000);

        // R1: reset in mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset rd_data", rd_data, 32'h0);
        check("R1 mid reset irq", {31'h0, irq_pulse}, 32'h0);
        rst_n = 1'b1;

        // R9: writing flag and master bits cannot set them
        drive(1'b1, 32'hFF00_0000, '0);
        @(negedge clk);
        check("R9 flags not writable", rd_data, 32'h0);
        check("R9 no irq", {31'h0, irq_pulse}, 32'h0);

        // R4: done with every enable off is ignored
        drive(1'b0, 32'h0, 7'h7F);
        @(negedge clk);
        check("R4 disabled done ignored", rd_data, 32'h0);
        drive(1'b0, 32'h0, '0);

        // R4: enable written in the same cycle as done does not gate that done
        drive(1'b1, 32'h0084_0000, 7'h04);
        @(negedge clk);
        check("R4 enable same cycle", rd_data, 32'h0084_0000);
        drive(1'b0, 32'h0, 7'h04);
        @(negedge clk);
        check("R4 enabled done sets", rd_data, 32'h8484_0000);
        check("R7 done raises irq", {31'h0, irq_pulse}, 32'h1);
        drive(1'b0, 32'h0, '0);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule